// File: doc/BRIEF.md
# Paired-Channel Bus Address Matcher

This block watches every access on an internal bus and decides, for one pair of neighbouring watch channels, whether each channel hits. It holds two 24-bit watch-address registers and one control word. The two registers can act as two independent point addresses, as a base address with an OR-mask, or as an inclusive start and end address. Every hit is also gated by eight access-attribute enables. These cover direction, size, code or data, and the bus master.

The match strobes are combinational and appear in the same cycle as a valid bus access. Blocks that compare data, replace data or deliver interrupts consume the strobes. Software programs the registers through a small select/write port. The address registers are written one byte slice at a time, and the same port gives a combinational read-back.

Top module: `pair_addr_matcher`

## Requirements
- R1: After reset, every address slice and the control word read back as 0, and no access hits while the control word is 0.
- R2: Select codes 0..2 write the low, middle and high bytes of watch register A from `cfg_wdata[7:0]`, and codes 3..5 do the same for watch register B. Code 6 writes control bits 15..6 from `cfg_wdata[15:6]`. A byte slice reads back in bits 7..0 with zeros above it, and the control word reads back with bits 5..0 as zero.
- R3: Point mode (control bit 7 = 0, bit 6 = 0): `hit[0]` asserts when the access address equals register A, and `hit[1]` asserts independently when it equals register B.
- R4: Mask mode (bit 7 = 1, bit 6 = 0): `hit[0]` asserts when the address equals register A in every bit where register B holds 0. Bits where register B holds 1 are not compared.
- R5: Range mode (bit 6 = 1) hits on `hit[0]` when A <= address <= B, both bounds included. In both mask and range mode, `hit[1]` never asserts.
- R6: Direction enables are bit 15 (read) and bit 14 (write). A read-modify-write access (`bus_rd` and `bus_wr` both 1) qualifies if either enable is set. An access with neither strobe never hits.
- R7: Size enables are bit 13 (8-bit) and bit 12 (16-bit). `bus_word` = 1 marks a 16-bit access, and an access qualifies only if the enable for its size is set.
- R8: Kind enables are bit 11 (code) and bit 10 (data), and master enables are bit 9 (CPU) and bit 8 (DMA). An access qualifies only if the enables for both its kind and its master are set. If both bits of either pair are 0, nothing ever hits.
- R9: A code access (`bus_code` = 1) issued by DMA (`bus_dma` = 1) never hits, whatever the enables.
- R10: A 16-bit access ignores address bit 0 in every comparison, so an odd word address hits a watch point set at the even address below it. An 8-bit access compares all 24 bits.
- R11: Hits are produced combinationally in the cycle of the access and are 0 whenever `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (slice or control word) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read-back of the selected register |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 24 | Access address |
| bus_rd | input | 1 | Access reads |
| bus_wr | input | 1 | Access writes (with bus_rd: read-modify-write) |
| bus_word | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| bus_code | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| hit | output | 2 | Per-channel match strobe |

## Verification
The hardest situations to reach from the ports are those in which the address matches but one attribute fails. These are a read-modify-write seen with only one direction enabled, an odd word address against an even watch point, and a DMA code fetch with every enable set. Table vectors therefore pair a matching address with single-bit changes to the control word or the access attributes. The odd channel's silence in mask mode is reached by sending the mask value itself as the bus address. The range vectors probe each bound and the address just beyond it.

// File: rtl/pair_addr_matcher.sv
module pair_addr_matcher #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic          bus_code,
  input  logic          bus_dma,
  output logic [1:0]    hit
);
  localparam int NSL   = AW / 8;
  localparam int CTLSEL = 2 * NSL;
  localparam int CB    = DW - 6;

  logic [AW-1:0] pt_q [2];
  logic [CB-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_q[0] <= '0;
      pt_q[1] <= '0;
      ctl_q   <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < NSL; i++)
          if (cfg_sel == 3'(k*NSL + i)) pt_q[k][i*8 +: 8] <= cfg_wdata[7:0];
      if (cfg_sel == 3'(CTLSEL)) ctl_q <= cfg_wdata[DW-1:6];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NSL; i++)
        if (cfg_sel == 3'(k*NSL + i)) cfg_rdata = {{(DW-8){1'b0}}, pt_q[k][i*8 +: 8]};
    if (cfg_sel == 3'(CTLSEL)) cfg_rdata = {ctl_q, 6'b0};
  end

  wire en_rd = ctl_q[9], en_wr = ctl_q[8], en_b = ctl_q[7], en_w = ctl_q[6];
  wire en_cd = ctl_q[5], en_dt = ctl_q[4], en_cpu = ctl_q[3], en_dma = ctl_q[2];
  wire am = ctl_q[1], ar = ctl_q[0];

  wire dir_ok  = (bus_rd & en_rd) | (bus_wr & en_wr);
  wire size_ok = bus_word ? en_w : en_b;
  wire kind_ok = bus_code ? (en_cd & ~bus_dma) : en_dt;
  wire mst_ok  = bus_dma ? en_dma : en_cpu;
  wire qual    = bus_valid & dir_ok & size_ok & kind_ok & mst_ok;

  wire [AW-1:0] ign  = {{(AW-1){1'b0}}, bus_word};
  wire [AW-1:0] eff  = bus_addr & ~ign;
  wire eq_a    = ((bus_addr ^ pt_q[0]) & ~ign) == '0;
  wire eq_b    = ((bus_addr ^ pt_q[1]) & ~ign) == '0;
  wire eq_mask = ((bus_addr ^ pt_q[0]) & ~(pt_q[1] | ign)) == '0;
  wire in_rng  = (eff >= pt_q[0]) && (eff <= pt_q[1]);

  assign hit[0] = qual & (ar ? in_rng : (am ? eq_mask : eq_a));
  assign hit[1] = qual & ~ar & ~am & eq_b;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> hit == 2'b00); // R11
  AST_DMA_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_code && bus_dma) |-> hit == 2'b00); // R9
  AST_NO_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |-> hit == 2'b00); // R6
  AST_ODD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:6] != 2'b00 && cfg_sel == 3'(CTLSEL)) |-> !hit[1]); // R5
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctl_q)); // R2
  AST_PAIR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_cd && !en_dt) || (!en_cpu && !en_dma) |-> hit == 2'b00); // R8
endmodule

// File: tb/pair_addr_matcher_tb.sv
`timescale 1ns/1ps
module pair_addr_matcher_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic bus_valid = 0, bus_rd = 0, bus_wr = 0, bus_word = 0, bus_code = 0, bus_dma = 0;
  logic [23:0] bus_addr = 0;
  logic [1:0] hit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_addr_matcher u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .bus_valid, .bus_addr, .bus_rd, .bus_wr, .bus_word, .bus_code, .bus_dma, .hit);

  // {req, ctl, regA, regB, addr, {rd,wr,word,code,dma}, exp}
  localparam int NV = 23;
  localparam logic [98:0] VEC [NV] = '{
    {4'd3, 16'hFF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10000, 2'b01}, // R3
    {4'd3, 16'hFF00, 24'hDF0000, 24'h006C00, 24'h006C00, 5'b10000, 2'b10}, // R3
    {4'd3, 16'hFF00, 24'hDF0000, 24'h006C00, 24'h006C02, 5'b10000, 2'b00}, // R3
    {4'd4, 16'hFF80, 24'hDF0000, 24'h000100, 24'hDF0100, 5'b10000, 2'b01}, // R4
    {4'd4, 16'hFF80, 24'hDF0000, 24'h000100, 24'hDF0200, 5'b10000, 2'b00}, // R4
    {4'd5, 16'hFF80, 24'hDF0000, 24'h000100, 24'h000100, 5'b10000, 2'b00}, // R5
    {4'd5, 16'hFF40, 24'h006C00, 24'h006CFE, 24'h006CFE, 5'b10000, 2'b01}, // R5
    {4'd5, 16'hFF40, 24'h006C00, 24'h006CFE, 24'h006CFF, 5'b10000, 2'b00}, // R5
    {4'd5, 16'hFF40, 24'h006C00, 24'h006CFE, 24'h006BFF, 5'b10000, 2'b00}, // R5
    {4'd5, 16'hFF40, 24'h006C00, 24'h006CFE, 24'h006C00, 5'b10000, 2'b01}, // R5
    {4'd6, 16'h7F00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10000, 2'b00}, // R6
    {4'd6, 16'h7F00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b11000, 2'b01}, // R6
    {4'd6, 16'hBF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b01000, 2'b00}, // R6
    {4'd6, 16'hFF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b00000, 2'b00}, // R6
    {4'd7, 16'hDF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10000, 2'b00}, // R7
    {4'd7, 16'hDF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10100, 2'b01}, // R7
    {4'd8, 16'hF700, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10010, 2'b00}, // R8
    {4'd8, 16'hF300, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10000, 2'b00}, // R8
    {4'd8, 16'hFC00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10000, 2'b00}, // R8
    {4'd8, 16'hFD00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10001, 2'b01}, // R8
    {4'd9, 16'hFF00, 24'hDF0000, 24'h006C00, 24'hDF0000, 5'b10011, 2'b00}, // R9
    {4'd10,16'hFF00, 24'hDF0000, 24'h006C00, 24'hDF0001, 5'b10100, 2'b01}, // R10
    {4'd10,16'hFF00, 24'hDF0000, 24'h006C00, 24'hDF0001, 5'b10000, 2'b00}  // R10
  };

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] c, input logic [23:0] a, input logic [23:0] b);
    for (int i = 0; i < 3; i++) wr(3'(i), {8'h0, a[i*8 +: 8]});
    for (int i = 0; i < 3; i++) wr(3'(3+i), {8'h0, b[i*8 +: 8]});
    wr(3'd6, c);
  endtask

  task automatic access(input logic [23:0] ad, input logic [4:0] at, input logic v);
    @(negedge clk);
    bus_valid = v; bus_addr = ad;
    {bus_rd, bus_wr, bus_word, bus_code, bus_dma} = at;
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int s = 0; s < 7; s++) begin
      @(negedge clk); cfg_sel = 3'(s); #1;
      check("R1", cfg_rdata, 16'h0);
    end
    access(24'h000000, 5'b10000, 1);
    check("R1", {14'h0, hit}, 16'h0);
    // R2: slice write and read-back
    load(16'hFFFF, 24'hA1B2C3, 24'h0D0E0F);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk); cfg_sel = 3'(s); #1;
      case (s)
        0: check("R2", cfg_rdata, 16'h00C3);
        1: check("R2", cfg_rdata, 16'h00B2);
        2: check("R2", cfg_rdata, 16'h00A1);
        3: check("R2", cfg_rdata, 16'h000F);
        4: check("R2", cfg_rdata, 16'h000E);
        5: check("R2", cfg_rdata, 16'h000D);
        default: check("R2", cfg_rdata, 16'hFFC0);
      endcase
    end
    // table
    for (int n = 0; n < NV; n++) begin
      logic [98:0] v;
      v = VEC[n];
      load(v[94:79], v[78:55], v[54:31]);
      access(v[30:7], v[6:2], 1);
      checks++;
      if (hit !== v[1:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual %b expected %b", v[98:95], n, hit, v[1:0]);
      end
    end
    // R11: valid low suppresses a matching access
    load(16'hFF00, 24'h123456, 24'h123456);
    access(24'h123456, 5'b10000, 1);
    check("R11", {14'h0, hit}, 16'h0003);
    access(24'h123456, 5'b10000, 0);
    check("R11", {14'h0, hit}, 16'h0000);
    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; cfg_sel = 3'd6; #1;
    check("R1", cfg_rdata, 16'h0);
    access(24'h123456, 5'b10000, 1);
    check("R1", {14'h0, hit}, 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule